// File: doc/BRIEF.md
# Edge-Pulse Isolated Data Channel

This block holds the digital logic of one isolated data channel. The transmit half samples an asynchronous level through a synchronizer. It turns every rising edge into a one-cycle set pulse and every falling edge into a one-cycle clear pulse. While the level stays still, it repeats the current level as a refresh pulse at a fixed interval, so the far side stays correct at DC. The receive half keeps the channel output in a set/clear latch that those pulses drive. A watchdog forces the output high when pulses stop arriving.

The barrier between the halves is not part of the block. The transmit pulses leave on `link_set_o`/`link_clr_o`, and the receiver takes its pulses from `link_set_i`/`link_clr_i`. The surrounding logic or the bench joins them, and can cut or corrupt the path there. Each half has its own power-good input. The refresh interval and the watchdog timeout are parameters counted in clock cycles.

Top module: `edge_pulse_link`

## Requirements
- R1: The transmitter never raises set and clear in the same cycle, and no pulse lasts longer than one cycle. When `din` changes level after a falling clock edge, the new level appears on `dout` after the fourth following rising edge. A rising level sends set and a falling level sends clear.
- R2: After `REFRESH_CYC` cycles with no pulse sent, the transmitter sends one refresh pulse that matches the synchronized level: set if it is high, clear if it is low. Every pulse sent restarts this interval.
- R3: A powered receiver drives `dout` to 1 in the cycle after a set-only pulse, and to 0 in the cycle after a clear-only pulse.
- R4: When set and clear arrive in the same cycle, `dout` keeps its value and `conflict` is 1 for exactly the next cycle.
- R5: Once any pulse has been received, `WDOG_CYC` cycles without a received pulse force `dout` to 1. It stays 1 until the next pulse.
- R6: While `tx_pwr_ok` is 0, no pulse is sent. Edge detection arms one cycle after `tx_pwr_ok` rises, so power-up creates no edge pulse.
- R7: While `rx_pwr_ok` is 0, `dout_en` and `dout` are 0 in the following cycle. After power-up `dout` stays 0 until the first pulse, and the watchdog stays disarmed until then.
- R8: When the transmitter loses power, `dout` keeps its last received level until the watchdog timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_pwr_ok | input | 1 | Transmit-side supply good |
| rx_pwr_ok | input | 1 | Receive-side supply good |
| din | input | 1 | Asynchronous channel input level |
| link_set_o | output | 1 | Transmitted set pulse |
| link_clr_o | output | 1 | Transmitted clear pulse |
| link_set_i | input | 1 | Received set pulse |
| link_clr_i | input | 1 | Received clear pulse |
| dout | output | 1 | Channel output level |
| dout_en | output | 1 | Output driven (1) or high impedance (0) |
| conflict | output | 1 | One-cycle flag for simultaneous set and clear |

## Verification
The checker watches these rules on every cycle:
- the transmitter never pulses both lines and never stretches a pulse;
- it stays quiet while unpowered;
- the latch follows single pulses and holds on a conflict;
- the receiver output is forced off while unpowered.

Some behaviour needs long timing windows, and only the bench's scenarios can show it: the refresh cadence on a held input, the exact edge-to-output latency, the watchdog's default-high level after the link is cut or the transmitter is powered down, and the disarmed watchdog after receiver power-up.

// File: rtl/edge_link_pkg.sv
package edge_link_pkg;
  typedef struct packed {
    logic set;
    logic clr;
  } pulse_t;

  localparam pulse_t PULSE_NONE = '{set: 1'b0, clr: 1'b0};
endpackage

// File: rtl/elk_sync.sv
module elk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/elk_tx.sv
module elk_tx
  import edge_link_pkg::*;
#(
  parameter int REFRESH_CYC = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_ok,
  input  logic   din,
  output pulse_t pls
);
  localparam int CW = (REFRESH_CYC > 1) ? $clog2(REFRESH_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(REFRESH_CYC - 1);

  logic          lvl;
  logic          armed_q, prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  pulse_t        pls_q, pls_d;
  logic          live, edge_hit, refresh_hit, send;

  elk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(lvl)
  );

  always_comb begin
    live        = armed_q & pwr_ok;
    edge_hit    = live & (lvl != prev_q);
    refresh_hit = live & ~edge_hit & (cnt_q == CNT_LAST);
    send        = edge_hit | refresh_hit;
    pls_d       = PULSE_NONE;
    if (send) begin
      pls_d.set = lvl;
      pls_d.clr = ~lvl;
    end
    if (!live || send) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      pls_q   <= PULSE_NONE;
    end else begin
      armed_q <= pwr_ok;
      prev_q  <= lvl;
      cnt_q   <= cnt_d;
      pls_q   <= pls_d;
    end
  end

  assign pls = pls_q;
endmodule

// File: rtl/elk_rx.sv
module elk_rx
  import edge_link_pkg::*;
#(
  parameter int WDOG_CYC = 500
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_ok,
  input  pulse_t pls,
  output logic   dout,
  output logic   dout_en,
  output logic   conflict
);
  localparam int WW = (WDOG_CYC > 1) ? $clog2(WDOG_CYC) : 1;
  localparam logic [WW-1:0] WD_LAST = WW'(WDOG_CYC - 1);

  logic          lvl_q, lvl_d;
  logic          en_q;
  logic          err_q, err_d;
  logic          seen_q, seen_d;
  logic [WW-1:0] wd_q, wd_d;
  logic          any_pls;

  always_comb begin
    any_pls = pls.set | pls.clr;
    lvl_d   = lvl_q;
    seen_d  = seen_q;
    wd_d    = wd_q;
    err_d   = 1'b0;
    if (!pwr_ok) begin
      lvl_d  = 1'b0;
      seen_d = 1'b0;
      wd_d   = '0;
    end else if (any_pls) begin
      seen_d = 1'b1;
      wd_d   = '0;
      err_d  = pls.set & pls.clr;
      if (pls.set & ~pls.clr) lvl_d = 1'b1;
      if (pls.clr & ~pls.set) lvl_d = 1'b0;
    end else if (seen_q) begin
      if (wd_q == WD_LAST) lvl_d = 1'b1;
      else                 wd_d  = wd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      seen_q <= 1'b0;
      wd_q   <= '0;
    end else begin
      lvl_q  <= lvl_d;
      en_q   <= pwr_ok;
      err_q  <= err_d;
      seen_q <= seen_d;
      wd_q   <= wd_d;
    end
  end

  assign dout     = lvl_q;
  assign dout_en  = en_q;
  assign conflict = err_q;
endmodule

// File: rtl/edge_pulse_link.sv
module edge_pulse_link
  import edge_link_pkg::*;
#(
  parameter int REFRESH_CYC = 100,
  parameter int WDOG_CYC    = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_pwr_ok,
  input  logic rx_pwr_ok,
  input  logic din,
  output logic link_set_o,
  output logic link_clr_o,
  input  logic link_set_i,
  input  logic link_clr_i,
  output logic dout,
  output logic dout_en,
  output logic conflict
);
  logic   rst_meta_q, rst_sync_q;
  pulse_t tx_pls, rx_pls;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  elk_tx #(.REFRESH_CYC(REFRESH_CYC), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk(clk), .rst_n(rst_sync_q), .pwr_ok(tx_pwr_ok), .din(din), .pls(tx_pls)
  );

  assign link_set_o = tx_pls.set;
  assign link_clr_o = tx_pls.clr;
  assign rx_pls     = '{set: link_set_i, clr: link_clr_i};

  elk_rx #(.WDOG_CYC(WDOG_CYC)) u_rx (
    .clk(clk), .rst_n(rst_sync_q), .pwr_ok(rx_pwr_ok), .pls(rx_pls),
    .dout(dout), .dout_en(dout_en), .conflict(conflict)
  );
endmodule

// File: rtl/edge_pulse_link_chk.sv
module edge_pulse_link_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_pwr_ok,
  input logic rx_pwr_ok,
  input logic link_set_o,
  input logic link_clr_o,
  input logic link_set_i,
  input logic link_clr_i,
  input logic dout,
  input logic dout_en,
  input logic conflict
);
  a_r1_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_set_o && link_clr_o));
  a_r1_set_single: assert property (@(posedge clk) disable iff (!rst_n)
    link_set_o |=> !link_set_o);
  a_r1_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    link_clr_o |=> !link_clr_o);
  a_r6_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pwr_ok |=> !(link_set_o || link_clr_o));
  a_r3_set_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pwr_ok && link_set_i && !link_clr_i) |=> dout);
  a_r3_clr_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pwr_ok && link_clr_i && !link_set_i) |=> !dout);
  a_r4_conflict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pwr_ok && link_set_i && link_clr_i) |=> (conflict && $stable(dout)));
  a_r4_flag_only_on_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_set_i && link_clr_i) |=> !conflict);
  a_r7_unpowered_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_pwr_ok |=> (!dout_en && !dout));
endmodule

bind edge_pulse_link edge_pulse_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_pwr_ok(tx_pwr_ok), .rx_pwr_ok(rx_pwr_ok),
  .link_set_o(link_set_o), .link_clr_o(link_clr_o),
  .link_set_i(link_set_i), .link_clr_i(link_clr_i),
  .dout(dout), .dout_en(dout_en), .conflict(conflict)
);

// File: tb/sim_edge_pulse_link.sv
`timescale 1ns/1ps
module sim_edge_pulse_link;
  localparam int REF = 100;
  localparam int WD  = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_pwr_ok = 1'b0, rx_pwr_ok = 1'b0, din = 1'b0;
  logic cut = 1'b0, inj_s = 1'b0, inj_c = 1'b0;
  logic set_o, clr_o, set_i, clr_i, dout, dout_en, conflict;

  int checks = 0, fails = 0, cyc = 0;

  assign set_i = cut ? inj_s : set_o;
  assign clr_i = cut ? inj_c : clr_o;

  always #4 clk = ~clk;

  edge_pulse_link #(.REFRESH_CYC(REF), .WDOG_CYC(WD)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_pwr_ok(tx_pwr_ok), .rx_pwr_ok(rx_pwr_ok),
    .din(din), .link_set_o(set_o), .link_clr_o(clr_o),
    .link_set_i(set_i), .link_clr_i(clr_i),
    .dout(dout), .dout_en(dout_en), .conflict(conflict)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_s, m_c, m_q, m_en, m_err, m_seen, m_armed, m_prev;
  int m_rcnt, m_wd, rst_age;
  bit dly[$];
  int refresh_seen;

  always @(posedge clk) begin
    bit lv, ev, rv, ps, pc;
    cyc++;
    if (!rst_n || rst_age < 2) begin
      if (!rst_n) rst_age = 0; else rst_age++;
      dly = '{1'b0, 1'b0};
      m_s = 0; m_c = 0; m_q = 0; m_en = 0; m_err = 0; m_seen = 0;
      m_armed = 0; m_prev = 0; m_rcnt = 0; m_wd = 0;
    end else begin
      ps = set_i; pc = clr_i;
      lv = dly.pop_front();
      dly.push_back(din);
      ev = m_armed && tx_pwr_ok && (lv != m_prev);
      rv = m_armed && tx_pwr_ok && !ev && (m_rcnt == REF - 1);
      if (rv) refresh_seen++;
      m_s = (ev || rv) && lv;
      m_c = (ev || rv) && !lv;
      if (!(m_armed && tx_pwr_ok) || ev || rv) m_rcnt = 0; else m_rcnt++;
      m_prev = lv;
      m_armed = tx_pwr_ok;
      m_en = rx_pwr_ok;
      m_err = 0;
      if (!rx_pwr_ok) begin
        m_q = 0; m_seen = 0; m_wd = 0;
      end else if (ps || pc) begin
        m_seen = 1; m_wd = 0; m_err = ps && pc;
        if (ps && !pc) m_q = 1;
        if (pc && !ps) m_q = 0;
      end else if (m_seen) begin
        if (m_wd == WD - 1) m_q = 1; else m_wd++;
      end
    end
  end

  always @(negedge clk) begin
    check("R1/R2/R6 set pulse", set_o, m_s);
    check("R1/R2/R6 clr pulse", clr_o, m_c);
    check("R3/R5/R8 dout", dout, m_q);
    check("R7 dout_en", dout_en, m_en);
    check("R4 conflict", conflict, m_err);
  end

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n;
    int np;
    ticks(3);
    check("R7 reset dout_en", dout_en, 0);
    check("R7 reset dout", dout, 0);
    rst_n = 1'b1;
    ticks(5);
    rx_pwr_ok = 1'b1;
    din = 1'b1;
    ticks(10);
    check("R6 no pulses while tx unpowered", set_o | clr_o, 0);
    tx_pwr_ok = 1'b1;
    ticks(20);
    check("R7 dout low before first pulse", dout, 0);
    // R6: level already high at power-up, first pulse is a refresh
    ticks(REF);
    check("R2 refresh set reaches dout", dout, 1);
    // R1 latency: falling level
    din = 1'b0;
    n = 0;
    while (dout !== 1'b0 && n < 20) begin ticks(1); n++; end
    check("R1 fall latency", n, 4);
    din = 1'b1;
    n = 0;
    while (dout !== 1'b1 && n < 20) begin ticks(1); n++; end
    check("R1 rise latency", n, 4);
    // R1 several patterns, narrow and wide
    for (int i = 0; i < 12; i++) begin
      din = ~din;
      ticks(1 + (i * 7) % 9);
    end
    din = 1'b0;
    ticks(10);
    // R2 held input: refresh cadence
    np = refresh_seen;
    ticks(3 * REF + 20);
    check("R2 refresh count on held input", refresh_seen - np, 3);
    check("R2 held low stays low", dout, 0);
    // R4 conflict injection
    cut = 1'b1; inj_s = 1'b1; inj_c = 1'b1;
    ticks(1);
    inj_s = 1'b0; inj_c = 1'b0;
    check("R4 conflict flag", conflict, 1);
    check("R4 dout held", dout, 0);
    ticks(1);
    check("R4 flag lasts one cycle", conflict, 0);
    // R5 cut link: default high after timeout
    ticks(WD - 20);
    check("R5 before timeout", dout, 0);
    ticks(40);
    check("R5 default high", dout, 1);
    cut = 1'b0;
    ticks(REF + 5);
    check("R5 next pulse restores level", dout, 0);
    // R8 tx power loss
    din = 1'b1;
    ticks(10);
    tx_pwr_ok = 1'b0;
    din = 1'b0;
    ticks(WD - 50);
    check("R8 last level kept", dout, 1);
    din = 1'b0;
    ticks(10);
    // R7 receiver power cycle with tx off
    rx_pwr_ok = 1'b0;
    ticks(2);
    check("R7 unpowered dout_en", dout_en, 0);
    check("R7 unpowered dout", dout, 0);
    rx_pwr_ok = 1'b1;
    ticks(WD + 50);
    check("R7 watchdog disarmed before first pulse", dout, 0);
    check("R7 powered dout_en", dout_en, 1);
    din = 1'b1;
    tx_pwr_ok = 1'b1;
    ticks(REF + 10);
    check("R6 re-armed tx delivers level", dout, 1);
    ticks(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule